// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Corrector

This block sits behind a pipelined analog-to-digital converter built from a chain of 1.5-bit stages and a closing 2-bit flash stage. Each stage hands over a three-valued decision. The decisions for one conversion do not arrive together: each stage reports one clock after the stage before it. The block first brings all decisions of a conversion into the same clock cycle. It then adds them with weights that overlap by half a bit, so that a wrong decision in one stage is absorbed by the stages after it. The result is one saturated 12-bit sample per conversion clock, marked by a valid strobe.

Each stage also has a signed trim constant that corrects that stage's gain error. The constants are held in three copies, and every read takes a bitwise majority of the three. A small controller owns the bank and has three states. In BANK_IDLE it waits. It moves BANK_IDLE→BANK_ARMED when a configuration write is accepted, and BANK_IDLE→BANK_REPAIR when the copies of any stage disagree. In BANK_ARMED it holds the write. It moves BANK_ARMED→BANK_IDLE at the next sample boundary, which is the edge on which an aligned sample is summed, and the held write is committed on that edge. In BANK_REPAIR it rewrites the voted value of the lowest disagreeing stage into all three copies and counts the repair. It then moves BANK_REPAIR→BANK_IDLE, or BANK_REPAIR→BANK_ARMED if a write arrives in the same cycle. A write accepted while in BANK_ARMED replaces the held one, and the state stays BANK_ARMED.

Top module: `adc_digital_corr`

## Requirements
- R1: Stage codes are coded 00 = 0, 01 = 1 and 10 = 2. Stage i (i = 0 to 9, carried on stage_code[2i+1:2i]) has weight 2^(10-i). The flash code (0 to 3) has weight 1. With all trims at zero, out_data equals the weighted sum.
- R2: A stage code of 11 on any lane is treated as 10. It also sets code_err, which then stays at 1 until reset. Every lane is checked in every cycle.
- R3: For a sample whose stage 0 code arrives with in_vld in cycle t, stage i is expected in cycle t+i and the flash code in cycle t+10. These skewed codes are combined into one sample.
- R4: out_vld is high exactly 12 cycles (stages plus two) after in_vld was sampled high, once per input sample. Back-to-back samples produce back-to-back outputs.
- R5: Stage i adds trim_i × (code_i − 1) to the sum. trim_i is the majority-voted 6-bit two's-complement constant of that stage.
- R6: The corrected sum is clamped to the range 0 to 4095.
- R7: A configuration write is held until the next sample boundary. The sample summed on that edge still uses the old constants, and later samples use the new ones. While idle the write waits. A newer accepted write replaces a held one, and a write naming stage 10 or higher is ignored.
- R8: Bit c of cfg_copy_mask selects copy c (c = 0, 1, 2) for the write. Each trim is read as the bitwise majority of its three copies, so a value written to one copy only does not change any output.
- R9: When the copies of a stage disagree, the voted value is written back into all three copies. upset_cnt then rises by exactly 1 per repaired stage and saturates at all ones.
- R10: Reset clears out_vld, out_data, code_err, upset_cnt and all trim copies to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Stage 0 code of a new sample is present |
| stage_code | input | 20 | Stage i code on bits [2i+1:2i], skewed i cycles |
| flash_code | input | 2 | Final flash code, skewed 10 cycles |
| cfg_we | input | 1 | Trim write request |
| cfg_stage | input | 4 | Stage index of the write |
| cfg_data | input | 6 | Signed trim value |
| cfg_copy_mask | input | 3 | Copies that receive the write |
| out_vld | output | 1 | Corrected sample valid |
| out_data | output | 12 | Corrected, saturated sample |
| code_err | output | 1 | Sticky flag for an illegal stage code |
| upset_cnt | output | 8 | Number of copy disagreements repaired |

## Verification
The latency property assumes that in_vld marks the cycle in which stage 0 of each sample appears. It also assumes that the other lanes follow with exactly the skew in R3. The stimulus builds every lane from a per-sample table and offsets each lane by its stage index. All lanes and in_vld are held at zero outside a stream, so no partial sample leaks into a result. Trim writes are issued only while the pipeline is idle. This makes the sample boundary that commits a write the first sample of the next stream, which the expected values rely on.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    // Controller states of the redundant trim bank
    typedef enum logic [1:0] {
        BANK_IDLE   = 2'd0,
        BANK_ARMED  = 2'd1,
        BANK_REPAIR = 2'd2
    } bank_state_t;

    localparam logic [1:0] CODE_ILLEGAL = 2'b11;
    localparam logic [1:0] CODE_HIGH    = 2'b10;

    // Map the unused code onto the highest legal decision
    function automatic logic [1:0] clamp_code(input logic [1:0] c);
        return (c == CODE_ILLEGAL) ? CODE_HIGH : c;
    endfunction

endpackage

// File: rtl/adc_stage_align.sv
module adc_stage_align
    import adc_corr_pkg::*;
#(
    parameter int N_STAGES = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [2*N_STAGES-1:0] stage_code,
    input  logic [1:0]            flash_code,
    output logic                  al_vld,
    output logic [2*N_STAGES-1:0] al_code,
    output logic [1:0]            al_flash,
    output logic                  code_err
);

    logic                  vld_q;
    logic [2*N_STAGES-1:0] code_q;
    logic [1:0]            flash_q;
    logic [N_STAGES-1:0]   bad;
    logic [N_STAGES-1:0]   vld_sh;

    always_comb begin
        for (int i = 0; i < N_STAGES; i++) begin
            bad[i] = (stage_code[2*i +: 2] == CODE_ILLEGAL);
        end
    end

    // Capture register: clamp illegal codes, raise the sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q    <= 1'b0;
            code_q   <= '0;
            flash_q  <= '0;
            code_err <= 1'b0;
        end else begin
            vld_q   <= in_vld;
            flash_q <= flash_code;
            for (int i = 0; i < N_STAGES; i++) begin
                code_q[2*i +: 2] <= clamp_code(stage_code[2*i +: 2]);
            end
            if (|bad) begin
                code_err <= 1'b1;
            end
        end
    end

    // Per-lane delay: lane g waits N_STAGES-g cycles to meet the flash code
    for (genvar g = 0; g < N_STAGES; g++) begin : g_lane
        localparam int DEPTH = N_STAGES - g;
        logic [1:0] tap [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int j = 0; j < DEPTH; j++) begin
                    tap[j] <= '0;
                end
            end else begin
                tap[0] <= code_q[2*g +: 2];
                for (int j = 1; j < DEPTH; j++) begin
                    tap[j] <= tap[j-1];
                end
            end
        end

        assign al_code[2*g +: 2] = tap[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_sh <= '0;
        end else begin
            vld_sh <= {vld_sh[N_STAGES-2:0], vld_q};
        end
    end

    assign al_vld   = vld_sh[N_STAGES-1];
    assign al_flash = flash_q;

endmodule

// File: rtl/adc_cal_bank.sv
module adc_cal_bank
    import adc_corr_pkg::*;
#(
    parameter  int N_STAGES = 10,
    parameter  int CAL_W    = 6,
    parameter  int CNT_W    = 8,
    localparam int SEL_W    = $clog2(N_STAGES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [SEL_W-1:0]            cfg_stage,
    input  logic [CAL_W-1:0]            cfg_data,
    input  logic [2:0]                  cfg_copy_mask,
    input  logic                        boundary,
    output logic [N_STAGES*CAL_W-1:0]   cal_vec,
    output logic [CNT_W-1:0]            upset_cnt
);

    localparam logic [SEL_W:0] STAGE_LIMIT = (SEL_W + 1)'(N_STAGES);

    bank_state_t          state_q, state_d;
    logic [CAL_W-1:0]     copy_q [3][N_STAGES];
    logic [CAL_W-1:0]     voted  [N_STAGES];
    logic [N_STAGES-1:0]  mism;
    logic                 mism_any;
    logic [SEL_W-1:0]     rep_idx;
    logic                 we_ok;
    logic [SEL_W-1:0]     pend_stage;
    logic [CAL_W-1:0]     pend_data;
    logic [2:0]           pend_mask;
    logic                 do_commit;
    logic                 do_repair;

    // Bitwise two-of-three vote and disagreement detect per stage
    for (genvar g = 0; g < N_STAGES; g++) begin : g_vote
        assign voted[g] = (copy_q[0][g] & copy_q[1][g]) |
                          (copy_q[0][g] & copy_q[2][g]) |
                          (copy_q[1][g] & copy_q[2][g]);
        assign mism[g]  = (copy_q[0][g] != copy_q[1][g]) ||
                          (copy_q[0][g] != copy_q[2][g]);
        assign cal_vec[g*CAL_W +: CAL_W] = voted[g];
    end

    assign mism_any = |mism;
    assign we_ok    = cfg_we && ({1'b0, cfg_stage} < STAGE_LIMIT);

    always_comb begin
        rep_idx = '0;
        for (int i = N_STAGES - 1; i >= 0; i--) begin
            if (mism[i]) begin
                rep_idx = SEL_W'(i);
            end
        end
    end

    // Held write: the newest accepted request wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_stage <= '0;
            pend_data  <= '0;
            pend_mask  <= '0;
        end else if (we_ok) begin
            pend_stage <= cfg_stage;
            pend_data  <= cfg_data;
            pend_mask  <= cfg_copy_mask;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BANK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_IDLE: begin
                if (we_ok) begin
                    state_d = BANK_ARMED;
                end else if (mism_any) begin
                    state_d = BANK_REPAIR;
                end
            end
            BANK_ARMED: begin
                if (boundary && !we_ok) begin
                    state_d = BANK_IDLE;
                end
            end
            BANK_REPAIR: begin
                state_d = we_ok ? BANK_ARMED : BANK_IDLE;
            end
            default: state_d = BANK_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        do_commit = 1'b0;
        do_repair = 1'b0;
        unique case (state_q)
            BANK_IDLE:   ;
            BANK_ARMED:  do_commit = boundary;
            BANK_REPAIR: do_repair = 1'b1;
            default:     ;
        endcase
    end

    // Triple storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin
                for (int s = 0; s < N_STAGES; s++) begin
                    copy_q[c][s] <= '0;
                end
            end
        end else if (do_commit) begin
            for (int c = 0; c < 3; c++) begin
                if (pend_mask[c]) begin
                    copy_q[c][pend_stage] <= pend_data;
                end
            end
        end else if (do_repair) begin
            for (int c = 0; c < 3; c++) begin
                copy_q[c][rep_idx] <= voted[rep_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upset_cnt <= '0;
        end else if (do_repair && (upset_cnt != '1)) begin
            upset_cnt <= upset_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_corr_sum.sv
module adc_corr_sum #(
    parameter  int N_STAGES = 10,
    parameter  int CAL_W    = 6,
    localparam int OUT_W    = N_STAGES + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      al_vld,
    input  logic [2*N_STAGES-1:0]     al_code,
    input  logic [1:0]                al_flash,
    input  logic [N_STAGES*CAL_W-1:0] cal_vec,
    output logic                      out_vld,
    output logic [OUT_W-1:0]          out_data
);

    localparam int MAX_CODE = (1 << OUT_W) - 1;

    logic signed [31:0] acc_d;
    logic signed [31:0] sum_q;
    logic               sum_vld;
    logic [OUT_W-1:0]   sat_d;

    // Overlapping weighted sum with per-stage gain trim
    always_comb begin
        int acc;
        int ci;
        int ki;
        acc = int'(al_flash);
        for (int i = 0; i < N_STAGES; i++) begin
            ci  = int'(al_code[2*i +: 2]);
            ki  = int'($signed(cal_vec[i*CAL_W +: CAL_W]));
            acc = acc + ci * (1 << (N_STAGES - i)) + ki * (ci - 1);
        end
        acc_d = acc;
    end

    always_comb begin
        if (sum_q < 0) begin
            sat_d = '0;
        end else if (sum_q > MAX_CODE) begin
            sat_d = OUT_W'(MAX_CODE);
        end else begin
            sat_d = sum_q[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_vld  <= 1'b0;
            sum_q    <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            sum_vld <= al_vld;
            if (al_vld) begin
                sum_q <= acc_d;
            end
            out_vld <= sum_vld;
            if (sum_vld) begin
                out_data <= sat_d;
            end
        end
    end

endmodule

// File: rtl/adc_digital_corr.sv
module adc_digital_corr
    import adc_corr_pkg::*;
#(
    parameter  int N_STAGES = 10,
    parameter  int CAL_W    = 6,
    parameter  int CNT_W    = 8,
    localparam int SEL_W    = $clog2(N_STAGES),
    localparam int OUT_W    = N_STAGES + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [2*N_STAGES-1:0] stage_code,
    input  logic [1:0]            flash_code,
    input  logic                  cfg_we,
    input  logic [SEL_W-1:0]      cfg_stage,
    input  logic [CAL_W-1:0]      cfg_data,
    input  logic [2:0]            cfg_copy_mask,
    output logic                  out_vld,
    output logic [OUT_W-1:0]      out_data,
    output logic                  code_err,
    output logic [CNT_W-1:0]      upset_cnt
);

    logic                      al_vld;
    logic [2*N_STAGES-1:0]     al_code;
    logic [1:0]                al_flash;
    logic [N_STAGES*CAL_W-1:0] cal_vec;

    adc_stage_align #(
        .N_STAGES (N_STAGES)
    ) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (in_vld),
        .stage_code (stage_code),
        .flash_code (flash_code),
        .al_vld     (al_vld),
        .al_code    (al_code),
        .al_flash   (al_flash),
        .code_err   (code_err)
    );

    // The edge that sums an aligned sample is the commit boundary
    adc_cal_bank #(
        .N_STAGES (N_STAGES),
        .CAL_W    (CAL_W),
        .CNT_W    (CNT_W)
    ) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_stage     (cfg_stage),
        .cfg_data      (cfg_data),
        .cfg_copy_mask (cfg_copy_mask),
        .boundary      (al_vld),
        .cal_vec       (cal_vec),
        .upset_cnt     (upset_cnt)
    );

    adc_corr_sum #(
        .N_STAGES (N_STAGES),
        .CAL_W    (CAL_W)
    ) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .al_vld   (al_vld),
        .al_code  (al_code),
        .al_flash (al_flash),
        .cal_vec  (cal_vec),
        .out_vld  (out_vld),
        .out_data (out_data)
    );

endmodule

// File: rtl/adc_digital_corr_chk.sv
module adc_digital_corr_chk #(
    parameter int N_STAGES = 10,
    parameter int CNT_W    = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2*N_STAGES-1:0] stage_code,
    input logic                  al_vld,
    input logic                  out_vld,
    input logic                  code_err,
    input logic [CNT_W-1:0]      upset_cnt
);

    logic any_bad;

    always_comb begin
        any_bad = 1'b0;
        for (int i = 0; i < N_STAGES; i++) begin
            if (stage_code[2*i +: 2] == 2'b11) begin
                any_bad = 1'b1;
            end
        end
    end

    // R2
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> code_err);

    // R2
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_bad |=> code_err);

    // R4
    vld_after_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        al_vld |-> ##2 out_vld);

    // R4
    vld_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(al_vld, 2));

    // R9
    cnt_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upset_cnt != $past(upset_cnt)) |-> (upset_cnt == $past(upset_cnt) + 1'b1));

    // R10
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_state_chk: assert (!out_vld && !code_err && (upset_cnt == '0));
        end
    end

endmodule

bind adc_digital_corr adc_digital_corr_chk #(
    .N_STAGES (N_STAGES),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_code (stage_code),
    .al_vld     (al_vld),
    .out_vld    (out_vld),
    .code_err   (code_err),
    .upset_cnt  (upset_cnt)
);

// File: tb/adc_digital_corr_test.sv
`timescale 1ns/1ps
module adc_digital_corr_test;

    localparam int NS = 10;

    typedef struct packed {
        logic [19:0] codes;
        logic [1:0]  flash;
        logic [11:0] expect_val;
    } vec_t;

    // R1 R3: ideal-weight vectors, trims all zero
    localparam vec_t TABLE [8] = '{
        '{20'h00000, 2'd0, 12'd0},
        '{20'h55555, 2'd0, 12'd2046},
        '{20'hAAAAA, 2'd3, 12'd4095},
        '{20'h00002, 2'd1, 12'd2049},
        '{20'h00001, 2'd2, 12'd1026},
        '{20'h00009, 2'd0, 12'd2048},
        '{20'h80000, 2'd3, 12'd7},
        '{20'hAAAA8, 2'd3, 12'd2047}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        in_vld = 1'b0;
    logic [19:0] stage_code = '0;
    logic [1:0]  flash_code = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_stage = '0;
    logic [5:0]  cfg_data = '0;
    logic [2:0]  cfg_copy_mask = '0;
    logic        out_vld;
    logic [11:0] out_data;
    logic        code_err;
    logic [7:0]  upset_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [19:0] sc [16];
    logic [1:0]  fl [16];
    int          ex [16];
    int          kmod [NS];

    always #4 clk = ~clk;

    adc_digital_corr uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_vld        (in_vld),
        .stage_code    (stage_code),
        .flash_code    (flash_code),
        .cfg_we        (cfg_we),
        .cfg_stage     (cfg_stage),
        .cfg_data      (cfg_data),
        .cfg_copy_mask (cfg_copy_mask),
        .out_vld       (out_vld),
        .out_data      (out_data),
        .code_err      (code_err),
        .upset_cnt     (upset_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Expected value from the requirement formulas
    function automatic int model(input logic [19:0] c, input logic [1:0] f);
        int acc;
        int ci;
        acc = int'(f);
        for (int i = 0; i < NS; i++) begin
            ci = int'(c[2*i +: 2]);
            if (ci == 3) ci = 2;
            acc = acc + ci * (1 << (NS - i)) + kmod[i] * (ci - 1);
        end
        if (acc < 0) acc = 0;
        if (acc > 4095) acc = 4095;
        return acc;
    endfunction

    task automatic cfg_write(input logic [3:0] s, input logic [5:0] d, input logic [2:0] m);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_stage = s;
        cfg_data = d;
        cfg_copy_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive k samples with per-lane skew; check valid timing and data (R3 R4)
    task automatic run_stream(input int k, input string tag);
        for (int t = 0; t < k + NS + 5; t++) begin
            int idx;
            bit expv;
            @(negedge clk);
            idx = t - NS - 3;
            expv = (idx >= 0) && (idx < k);
            chk(out_vld == expv, "R4 out_vld timing", int'(out_vld), int'(expv));
            if (expv) begin
                chk(int'(out_data) == ex[idx], tag, int'(out_data), ex[idx]);
            end
            in_vld = (t < k);
            for (int i = 0; i < NS; i++) begin
                int s;
                s = t - i;
                stage_code[2*i +: 2] = (s >= 0 && s < k) ? sc[s][2*i +: 2] : 2'b00;
            end
            flash_code = (t - NS >= 0 && t - NS < k) ? fl[t - NS] : 2'b00;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) kmod[i] = 0;
        #1 rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(out_vld == 1'b0, "R10 out_vld", int'(out_vld), 0);
        chk(out_data == 12'd0, "R10 out_data", int'(out_data), 0);
        chk(code_err == 1'b0, "R10 code_err", int'(code_err), 0);
        chk(upset_cnt == 8'd0, "R10 upset_cnt", int'(upset_cnt), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: R1 weights, R3 alignment, R4 back-to-back
        for (int v = 0; v < 8; v++) begin
            sc[v] = TABLE[v].codes;
            fl[v] = TABLE[v].flash;
            ex[v] = int'(TABLE[v].expect_val);
        end
        run_stream(8, "R1 weighted sum");

        // R7 deferral across an idle gap, R5 trim, R6 low clamp
        cfg_write(4'd0, 6'd5, 3'b111);
        repeat (20) @(negedge clk);
        sc[0] = 20'h00002; fl[0] = 2'd0; ex[0] = model(sc[0], fl[0]);
        kmod[0] = 5;
        sc[1] = 20'h00002; fl[1] = 2'd0; ex[1] = model(sc[1], fl[1]);
        sc[2] = 20'h00000; fl[2] = 2'd0; ex[2] = model(sc[2], fl[2]);
        chk(ex[1] == 2053 && ex[2] == 0, "R5 R6 model", ex[1], 2053);
        run_stream(3, "R7 R5 R6 deferred trim");

        // R7 newest write wins, out-of-range stage ignored; R6 high clamp
        cfg_write(4'd1, 6'h3C, 3'b111);
        cfg_write(4'd1, 6'd3, 3'b111);
        cfg_write(4'd10, 6'd20, 3'b111);
        sc[0] = 20'h00008; fl[0] = 2'd1; ex[0] = model(sc[0], fl[0]);
        kmod[1] = 3;
        sc[1] = 20'h00008; fl[1] = 2'd1; ex[1] = model(sc[1], fl[1]);
        sc[2] = 20'hAAAAA; fl[2] = 2'd3; ex[2] = model(sc[2], fl[2]);
        run_stream(3, "R7 R6 latest write");

        // R8 single-copy write is outvoted; R9 repair and count
        cfg_write(4'd2, 6'd9, 3'b001);
        sc[0] = 20'h00020; fl[0] = 2'd0; ex[0] = model(sc[0], fl[0]);
        sc[1] = 20'h00020; fl[1] = 2'd0; ex[1] = model(sc[1], fl[1]);
        run_stream(2, "R8 vote copy0");
        chk(upset_cnt == 8'd1, "R9 first repair", int'(upset_cnt), 1);
        cfg_write(4'd2, 6'd9, 3'b010);
        run_stream(2, "R9 R8 repaired copy0");
        chk(upset_cnt == 8'd2, "R9 second repair", int'(upset_cnt), 2);

        // R2 illegal code treated as 10, sticky flag
        chk(code_err == 1'b0, "R2 flag clear", int'(code_err), 0);
        sc[0] = 20'h000C0; fl[0] = 2'd0; ex[0] = model(sc[0], fl[0]);
        run_stream(1, "R2 clamped code");
        chk(code_err == 1'b1, "R2 flag set", int'(code_err), 1);
        sc[0] = 20'h55555; fl[0] = 2'd2; ex[0] = model(sc[0], fl[0]);
        run_stream(1, "R2 legal after error");
        chk(code_err == 1'b1, "R2 flag sticky", int'(code_err), 1);

        // R10 reset clears outputs, flag, counter and trims
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_data == 12'd0, "R10 out_data after run", int'(out_data), 0);
        chk(code_err == 1'b0, "R10 code_err after run", int'(code_err), 0);
        chk(upset_cnt == 8'd0, "R10 upset_cnt after run", int'(upset_cnt), 0);
        chk(out_vld == 1'b0, "R10 out_vld after run", int'(out_vld), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NS; i++) kmod[i] = 0;
        sc[0] = 20'h00000; fl[0] = 2'd0; ex[0] = model(sc[0], fl[0]);
        sc[1] = 20'h55555; fl[1] = 2'd0; ex[1] = model(sc[1], fl[1]);
        run_stream(2, "R10 trims cleared");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule